// File: doc/BRIEF.md
# Configurable Radio Packet Framer

This block turns bytes queued by a host into one outgoing radio packet, emitted as a serial bit stream at one bit per clock. A packet is made of a warm-up run of alternating ones and zeros, a programmable sync word, a short alternating tail, and then the data section. The data section is an optional length byte, the payload bytes and an optional 16-bit check value. Each field has a programmable length, and every field is sent most significant bit first. The data section can be Manchester coded; the leading fields are always sent NRZ.

The host loads payload bytes into an internal 64-byte queue through a byte-wide write port. It can keep topping the queue up while a packet is on the air, which is how packets longer than the queue are sent. In automatic length mode, the first queued byte states how many payload bytes follow, and the framer ends the packet by itself. In manual mode, the packet ends at the first byte boundary where the queue is empty. If the queue runs dry too early in automatic mode, the packet is abandoned and an underrun pulse is raised.

Top module: `radio_pkt_framer`

## Requirements
- R1: After a `start` pulse from idle, the first field is `8*(cfg_pre_bytes+1)` bits (1 to 8 bytes) of alternating bits, beginning with a 1.
- R2: The sync field follows, with length `16*(cfg_sync_sel+1)` bits (16, 32, 48 or 64). It carries bits `[L-1:0]` of `cfg_sync_word`, most significant of those first.
- R3: The tail field follows, with length `4+2*cfg_trl_code` bits (4 to 18 in steps of 2), of alternating bits beginning with a 1.
- R4: With `cfg_len_auto`=1, the first queued byte is sent as the length byte L (0 to 255), followed by exactly L further queued bytes, and then the packet ends.
- R5: With `cfg_len_auto`=0, no length byte is sent, and queued bytes are sent until the queue is empty at a byte boundary. A packet started on an empty queue carries no payload.
- R6: With `cfg_crc_en`=1, a 16-bit check (polynomial 0x1021, preset 0xFFFF, bytes fed most significant bit first) over the length byte and payload is appended, most significant bit first.
- R7: With `cfg_manch`=1, every bit b of the length byte, payload and check is sent as b followed by its inverse. The preamble, sync and tail fields stay NRZ.
- R8: The queue holds 64 bytes. `fifo_full` is high at 64 entries and a write while full is dropped. `fifo_empty` is high at zero entries.
- R9: `tx_valid` is high on exactly the cycles that carry packet bits. `pkt_done` pulses for one cycle in the cycle right after the last bit of a completed packet.
- R10: In automatic mode, if the queue is empty when the next byte is needed, the packet stops after the current bit, `underrun` pulses for one cycle, and `pkt_done` does not pulse.
- R11: A `start` pulse while a packet is in progress is ignored.
- R12: After reset, `tx_valid`, `pkt_done`, `underrun` and `fifo_full` are low, and `fifo_empty` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a packet when idle |
| cfg_pre_bytes | input | 3 | Preamble bytes minus one |
| cfg_sync_sel | input | 2 | Sync length code (16*(code+1) bits) |
| cfg_sync_word | input | 64 | Sync pattern, low L bits used |
| cfg_trl_code | input | 3 | Tail length code (4+2*code bits) |
| cfg_len_auto | input | 1 | Automatic length byte mode |
| cfg_crc_en | input | 1 | Append 16-bit check |
| cfg_manch | input | 1 | Manchester-code the data section |
| wr_en | input | 1 | Queue write strobe |
| wr_data | input | 8 | Queue write byte |
| fifo_full | output | 1 | Queue holds 64 bytes |
| fifo_empty | output | 1 | Queue holds no bytes |
| tx_bit | output | 1 | Serial packet bit |
| tx_valid | output | 1 | `tx_bit` carries a packet bit |
| pkt_done | output | 1 | One-cycle pulse after a completed packet |
| underrun | output | 1 | One-cycle pulse on an abandoned packet |

## Verification
The hardest situation to reach is a packet that is longer than the queue in automatic mode. Such a packet only completes if the queue is refilled while bits are flowing, and it only underruns if the refill stops short. The bench drives its writes from the same per-cycle loop that samples the serial output, so it writes whenever `fifo_full` is low and a byte is left to send. A 255-byte packet therefore passes through the 64-entry queue several times. Withholding the last bytes of a packet, or the length byte itself, produces underruns at both possible points. A full sweep over every preamble, sync and tail length, with coding and check enable varied, covers all header lengths.

// File: rtl/rpf_pkg.sv
package rpf_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE,
        S_SYNC,
        S_TRL,
        S_LEN,
        S_PAY,
        S_CRC
    } fstate_e;

    localparam logic [15:0] CRC_POLY = 16'h1021;
    localparam logic [15:0] CRC_SEED = 16'hFFFF;

endpackage

// File: rtl/rpf_fifo.sv
module rpf_fifo #(
    parameter int DEPTH = 64,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          full,
    output logic          empty
);
    // DEPTH must be a power of two so the pointers wrap naturally.
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [AW:0]   cnt;
    } ptr_t;

    ptr_t q, d;
    logic do_wr, do_rd;
    logic [DW-1:0] mem [DEPTH];

    always_comb begin
        d     = q;
        do_wr = wr_en && (q.cnt != FULL_CNT);
        do_rd = rd_en && (q.cnt != '0);
        if (do_wr) d.wp = q.wp + 1'b1;
        if (do_rd) d.rp = q.rp + 1'b1;
        d.cnt = q.cnt + (AW+1)'(do_wr) - (AW+1)'(do_rd);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[q.wp] <= wr_data;
    end

    assign rd_data = mem[q.rp];
    assign full    = (q.cnt == FULL_CNT);
    assign empty   = (q.cnt == '0);

endmodule

// File: rtl/rpf_crc16.sv
module rpf_crc16 #(
    parameter logic [15:0] POLY = 16'h1021
) (
    input  logic [15:0] crc_in,
    input  logic [7:0]  data,
    output logic [15:0] crc_out
);
    logic [15:0] acc;

    // One byte folded in, most significant bit first.
    always_comb begin
        acc = crc_in;
        for (int i = 7; i >= 0; i--) begin
            if (acc[15] ^ data[i]) acc = (acc << 1) ^ POLY;
            else                   acc = acc << 1;
        end
        crc_out = acc;
    end

endmodule

// File: rtl/radio_pkt_framer.sv
module radio_pkt_framer
    import rpf_pkg::*;
#(
    parameter int FIFO_DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [2:0]  cfg_pre_bytes,
    input  logic [1:0]  cfg_sync_sel,
    input  logic [63:0] cfg_sync_word,
    input  logic [2:0]  cfg_trl_code,
    input  logic        cfg_len_auto,
    input  logic        cfg_crc_en,
    input  logic        cfg_manch,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    output logic        fifo_full,
    output logic        fifo_empty,
    output logic        tx_bit,
    output logic        tx_valid,
    output logic        pkt_done,
    output logic        underrun
);
    localparam int SHW = 64;
    localparam int CW  = $clog2(SHW);
    localparam logic [SHW-1:0] ALT = {(SHW/2){2'b10}};

    typedef struct packed {
        fstate_e        st;
        logic [SHW-1:0] sh;
        logic [CW-1:0]  cnt;
        logic           mph;
        logic [7:0]     rem;
        logic [15:0]    crc;
        logic           done;
        logic           urun;
    } core_t;

    core_t q, n;

    logic        pop;
    logic [7:0]  fifo_rd_data;
    logic [15:0] crc_next;
    logic        coded, step, go_fetch, go_finish;
    logic        man_second;
    fstate_e     tgt;

    rpf_fifo #(.DEPTH(FIFO_DEPTH), .DW(8)) fifo_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (pop),
        .rd_data (fifo_rd_data),
        .full    (fifo_full),
        .empty   (fifo_empty)
    );

    rpf_crc16 #(.POLY(CRC_POLY)) crc_i (
        .crc_in  (q.crc),
        .data    (fifo_rd_data),
        .crc_out (crc_next)
    );

    assign coded = cfg_manch && (q.st == S_LEN || q.st == S_PAY || q.st == S_CRC);
    assign step  = !coded || q.mph;

    always_comb begin
        n         = q;
        n.done    = 1'b0;
        n.urun    = 1'b0;
        pop       = 1'b0;
        go_fetch  = 1'b0;
        go_finish = 1'b0;
        tgt       = S_PAY;

        if (q.st == S_IDLE) begin
            if (start) begin
                n.st  = S_PRE;
                n.sh  = ALT;
                n.cnt = CW'({cfg_pre_bytes, 3'b111});
                n.crc = CRC_SEED;
                n.mph = 1'b0;
                n.rem = '0;
            end
        end else begin
            if (coded) n.mph = ~q.mph;
            if (step) begin
                n.sh  = q.sh << 1;
                n.cnt = q.cnt - 1'b1;
                if (q.cnt == '0) begin
                    case (q.st)
                        S_PRE: begin
                            n.st  = S_SYNC;
                            n.sh  = cfg_sync_word << {~cfg_sync_sel, 4'b0000};
                            n.cnt = CW'({cfg_sync_sel, 4'b1111});
                        end
                        S_SYNC: begin
                            n.st  = S_TRL;
                            n.sh  = ALT;
                            n.cnt = CW'({cfg_trl_code, 1'b1}) + CW'(2);
                        end
                        S_TRL: begin
                            if (cfg_len_auto) begin
                                go_fetch = 1'b1;
                                tgt      = S_LEN;
                            end else if (fifo_empty) begin
                                go_finish = 1'b1;
                            end else begin
                                go_fetch = 1'b1;
                            end
                        end
                        S_LEN: begin
                            if (q.rem == '0) go_finish = 1'b1;
                            else             go_fetch  = 1'b1;
                        end
                        S_PAY: begin
                            if (cfg_len_auto ? (q.rem == '0) : fifo_empty) go_finish = 1'b1;
                            else                                          go_fetch  = 1'b1;
                        end
                        S_CRC: begin
                            n.st   = S_IDLE;
                            n.done = 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
        end

        if (go_fetch) begin
            if (fifo_empty) begin
                n.st   = S_IDLE;
                n.urun = 1'b1;
            end else begin
                pop   = 1'b1;
                n.st  = tgt;
                n.sh  = {fifo_rd_data, {(SHW-8){1'b0}}};
                n.cnt = CW'(7);
                n.crc = crc_next;
                n.rem = (tgt == S_LEN) ? fifo_rd_data : q.rem - 8'd1;
            end
        end

        if (go_finish) begin
            if (cfg_crc_en) begin
                n.st  = S_CRC;
                n.sh  = {q.crc, {(SHW-16){1'b0}}};
                n.cnt = CW'(15);
            end else begin
                n.st   = S_IDLE;
                n.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= S_IDLE;
        end else begin
            q <= n;
        end
    end

    assign tx_valid   = (q.st != S_IDLE);
    assign tx_bit     = q.sh[SHW-1] ^ (coded & q.mph);
    assign pkt_done   = q.done;
    assign underrun   = q.urun;
    assign man_second = coded & q.mph;

endmodule

// File: rtl/rpf_checker.sv
module rpf_checker (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic tx_bit,
    input logic tx_valid,
    input logic fifo_full,
    input logic fifo_empty,
    input logic pkt_done,
    input logic underrun,
    input logic man_second
);

    assert_launch_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !tx_valid) |=> (tx_valid && tx_bit));

    assert_manch_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
        man_second |-> (tx_bit != $past(tx_bit)));

    assert_full_not_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !fifo_empty);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> !tx_valid);

    assert_end_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_valid) |-> (pkt_done || underrun));

    assert_flags_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(pkt_done && underrun));

    assert_urun_after_tx_R10: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> $past(tx_valid));

endmodule

bind radio_pkt_framer rpf_checker chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .tx_bit     (tx_bit),
    .tx_valid   (tx_valid),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty),
    .pkt_done   (pkt_done),
    .underrun   (underrun),
    .man_second (man_second)
);

// File: tb/radio_pkt_framer_tb_top.sv
`timescale 1ns/1ps
module radio_pkt_framer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  cfg_pre_bytes = '0;
    logic [1:0]  cfg_sync_sel = '0;
    logic [63:0] cfg_sync_word = 64'hC3A5_1E0F_96D2_4B78;
    logic [2:0]  cfg_trl_code = '0;
    logic        cfg_len_auto = 1'b0;
    logic        cfg_crc_en = 1'b0;
    logic        cfg_manch = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        fifo_full, fifo_empty, tx_bit, tx_valid, pkt_done, underrun;

    always #2 clk = ~clk;

    radio_pkt_framer dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_pre_bytes(cfg_pre_bytes), .cfg_sync_sel(cfg_sync_sel),
        .cfg_sync_word(cfg_sync_word), .cfg_trl_code(cfg_trl_code),
        .cfg_len_auto(cfg_len_auto), .cfg_crc_en(cfg_crc_en), .cfg_manch(cfg_manch),
        .wr_en(wr_en), .wr_data(wr_data), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
        .tx_bit(tx_bit), .tx_valid(tx_valid), .pkt_done(pkt_done), .underrun(underrun)
    );

    int checks = 0;
    int errors = 0;
    int total_cycles = 0;
    bit exp_q[$];
    bit got_q[$];
    bit exp_ur;
    logic [7:0] feed_q[$];
    logic [7:0] pkt_bytes[$];
    int n_done, n_ur;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    always @(posedge clk) begin
        total_cycles++;
        if (total_cycles > 190000) begin
            errors++;
            $display("FAIL R9 watchdog actual=%0d expected<%0d", total_cycles, 190000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [15:0] crc_step(input logic [15:0] c_in, input logic [7:0] b);
        logic [15:0] c;
        c = c_in ^ {b, 8'h00};
        for (int k = 0; k < 8; k++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
        return c;
    endfunction

    task automatic push_field(input logic [63:0] v, input int nb, input bit man);
        for (int i = nb - 1; i >= 0; i--) begin
            exp_q.push_back(v[i]);
            if (man) exp_q.push_back(~v[i]);
        end
    endtask

    // Expected stream from the configuration and every byte the queue will receive.
    task automatic build(input int pre, input int sel, input int trl,
                         input bit auto_m, input bit crc_m, input bit man);
        logic [15:0] c;
        int len;
        exp_q.delete();
        exp_ur = 1'b0;
        c = 16'hFFFF;
        push_field({32{2'b10}}, 8 * pre, 1'b0);
        push_field(cfg_sync_word, 16 * (sel + 1), 1'b0);
        push_field({32{2'b10}}, 4 + 2 * trl, 1'b0);
        if (auto_m) begin
            if (pkt_bytes.size() == 0) begin exp_ur = 1'b1; return; end
            len = pkt_bytes[0];
            push_field(64'(pkt_bytes[0]), 8, man);
            c = crc_step(c, pkt_bytes[0]);
            for (int k = 1; k <= len; k++) begin
                if (k >= pkt_bytes.size()) begin exp_ur = 1'b1; return; end
                push_field(64'(pkt_bytes[k]), 8, man);
                c = crc_step(c, pkt_bytes[k]);
            end
        end else begin
            foreach (pkt_bytes[k]) begin
                push_field(64'(pkt_bytes[k]), 8, man);
                c = crc_step(c, pkt_bytes[k]);
            end
        end
        if (crc_m) push_field(64'(c), 16, man);
    endtask

    task automatic feed();
        if (feed_q.size() > 0 && !fifo_full) begin
            wr_en   = 1'b1;
            wr_data = feed_q.pop_front();
        end else begin
            wr_en = 1'b0;
        end
    endtask

    task automatic run_pkt(input bit extra_start);
        got_q.delete();
        n_done = 0;
        n_ur = 0;
        @(negedge clk);
        start = 1'b1;
        feed();
        for (int cyc = 0; cyc < 6000; cyc++) begin
            @(negedge clk);
            start = extra_start && (cyc == 20);
            if (tx_valid) got_q.push_back(tx_bit);
            if (pkt_done) n_done++;
            if (underrun) n_ur++;
            if (n_done + n_ur > 0) break;
            feed();
        end
        wr_en = 1'b0;
        start = 1'b0;
    endtask

    task automatic compare(input string tag);
        int bad;
        bad = -1;
        check(got_q.size() == exp_q.size(), tag, "bit count", got_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            if (got_q[i] != exp_q[i] && bad < 0) bad = i;
        check(bad < 0, tag, "first mismatching bit index", bad, -1);
        check(n_done == (exp_ur ? 0 : 1) && n_ur == (exp_ur ? 1 : 0), tag,
              "done/underrun pulses (done*10+ur)", n_done * 10 + n_ur,
              exp_ur ? 1 : 10);
    endtask

    task automatic setup(input int pre, input int sel, input int trl,
                         input bit auto_m, input bit crc_m, input bit man);
        cfg_pre_bytes = 3'(pre - 1);
        cfg_sync_sel  = 2'(sel);
        cfg_trl_code  = 3'(trl);
        cfg_len_auto  = auto_m;
        cfg_crc_en    = crc_m;
        cfg_manch     = man;
        build(pre, sel, trl, auto_m, crc_m, man);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        check(tx_valid == 0 && pkt_done == 0 && underrun == 0, "R12", "idle outputs",
              {tx_valid, pkt_done, underrun}, 0);
        check(fifo_empty == 1 && fifo_full == 0, "R12", "queue flags (empty,full)",
              {fifo_empty, fifo_full}, 2);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R3 R5 R6 R7: sweep of all header lengths, manual mode
        for (int p = 1; p <= 8; p++)
            for (int s = 0; s < 4; s++)
                for (int t = 0; t < 8; t++) begin
                    pkt_bytes.delete();
                    pkt_bytes.push_back(8'(p * 37 + s * 11 + t));
                    pkt_bytes.push_back(8'h5C ^ 8'(t * 19));
                    feed_q = pkt_bytes;
                    setup(p, s, t, 1'b0, bit'(s[0] ^ p[0]), bit'(t[0]));
                    run_pkt(1'b0);
                    compare("R1_R2_R3_R5_R6_R7 sweep");
                end

        // R4 R6: automatic length 5 with check, NRZ
        pkt_bytes = '{8'd5, 8'h00, 8'hFF, 8'h81, 8'h7E, 8'h3C};
        feed_q = pkt_bytes;
        setup(3, 3, 0, 1'b1, 1'b1, 1'b0);
        run_pkt(1'b0);
        compare("R4_R6 auto len 5");

        // R4: zero length, Manchester, no check
        pkt_bytes = '{8'd0};
        feed_q = pkt_bytes;
        setup(1, 0, 7, 1'b1, 1'b0, 1'b1);
        run_pkt(1'b0);
        compare("R4_R7 auto len 0");

        // R4 R8: 255-byte packet refilled through the 64-byte queue
        pkt_bytes.delete();
        pkt_bytes.push_back(8'd255);
        for (int k = 0; k < 255; k++) pkt_bytes.push_back(8'(k * 13 + 7));
        feed_q = pkt_bytes;
        setup(2, 1, 2, 1'b1, 1'b1, 1'b1);
        run_pkt(1'b0);
        compare("R4_R8 auto len 255 with refill");

        // R10: length says 3 but only 2 payload bytes arrive
        pkt_bytes = '{8'd3, 8'hA1, 8'hB2};
        feed_q = pkt_bytes;
        setup(1, 0, 0, 1'b1, 1'b1, 1'b0);
        run_pkt(1'b0);
        compare("R10 underrun mid payload");

        // R10: no length byte at all
        pkt_bytes.delete();
        feed_q.delete();
        setup(2, 0, 1, 1'b1, 1'b1, 1'b0);
        run_pkt(1'b0);
        compare("R10 underrun at length byte");

        // R5 R6: manual mode, empty queue, check of nothing
        pkt_bytes.delete();
        setup(1, 0, 0, 1'b0, 1'b1, 1'b0);
        run_pkt(1'b0);
        compare("R5_R6 empty payload");

        // R11: second start in the middle of a packet
        pkt_bytes = '{8'h12, 8'h34, 8'h56};
        feed_q = pkt_bytes;
        setup(4, 2, 3, 1'b0, 1'b1, 1'b0);
        run_pkt(1'b1);
        compare("R11 start while busy");
        @(negedge clk);
        check(tx_valid == 0 && pkt_done == 0, "R11", "no restart after done",
              {tx_valid, pkt_done}, 0);

        // R8: overfill the queue, extra writes dropped
        for (int k = 0; k < 70; k++) begin
            @(negedge clk);
            wr_en = 1'b1;
            wr_data = 8'(k + 1);
        end
        @(negedge clk);
        wr_en = 1'b0;
        check(fifo_full == 1 && fifo_empty == 0, "R8", "flags after 70 writes (full,empty)",
              {fifo_full, fifo_empty}, 2);
        pkt_bytes.delete();
        for (int k = 0; k < 64; k++) pkt_bytes.push_back(8'(k + 1));
        feed_q.delete();
        setup(1, 0, 0, 1'b0, 1'b1, 1'b0);
        run_pkt(1'b0);
        compare("R8 only first 64 bytes kept");
        check(fifo_empty == 1, "R8", "queue empty after drain", fifo_empty, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule